// File: doc/BRIEF.md
# Converter Serial Readout Interface

This block is the digital output side of a 16-bit sampling converter. A host raises the conversion strobe `cnv`. A conversion-time counter then runs, and when it expires the block captures a parallel result word. That word stands in for the analog conversion. The host reads the word back one bit at a time on `sdo`, most significant bit first, by toggling `sck`. All three host lines are oversampled in the `clk` domain. Edges are found by comparing each line with its value one cycle earlier.

At every accepted `cnv` rising edge, the block latches an operating mode from the level `sdi` had just before that edge.

- Select mode (`sdi` high) serves SPI-style hosts in two ways:
  - Three-wire use: `sdi` is tied high and `cnv` low enables readback.
  - Four-wire use: `cnv` stays high and `sdi` low acts as a separate read enable.
- Chain mode (`sdi` low) turns the device into a shift register. After its own word, `sdo` repeats the bits that arrive on `sdi`, so several devices cascade on one line.
- An optional start bit (a 0) can lead the data, so the host can detect the end of a conversion. Its enable rule depends on the mode.

The controller has three states:
- `ST_IDLE`: after reset.
- `ST_CONV`: the conversion is running.
- `ST_READ`: the result is held for shifting.

It has three transitions:
- IDLE to CONV: on an accepted `cnv` rise.
- CONV to READ: when the counter expires.
- READ to CONV: on the next `cnv` rise.

Top module: `adc_serial_port`

## Requirements
- R1: On a `cnv` rising edge outside a conversion, the mode is latched from the `sdi` level sampled one clock before the edge: 1 gives select mode, 0 gives chain mode. When `sdi` and `cnv` rise in the same cycle, chain mode results.
- R2: A conversion lasts exactly `CONV_CYCLES` clocks from the edge. At its end `conv_result` is captured. `sck` edges and further `cnv` rises during the conversion have no effect.
- R3: The captured word leaves on `sdo` most significant bit first. The first bit is present as soon as the conversion ends, and each `sck` falling edge advances one bit.
- R4: In select mode, `sdo_oe` is 0 during a conversion and whenever the device is not selected. With `sdi` held high, it is 1 in the readback state exactly while `cnv` is low.
- R5: In select mode with `cnv` held high, `sdi` low selects the device for readback (`sdo_oe` = 1 and bits advance). `sdi` high deselects it.
- R6: In select mode, if `cnv` or `sdi` is low in the cycle the conversion ends, a start bit of value 0 precedes the 16 data bits. Otherwise the data begins at once.
- R7: In chain mode, if `sck` was high one clock before the `cnv` rise, a 0 start bit precedes the data, and `sdo` is 1 during that conversion.
- R8: In chain mode, after the start bit (if any) and the 16 data bits, `sdo` presents in order the `sdi` levels sampled at successive `sck` rising edges. Two cascaded devices therefore deliver the downstream word followed by the upstream word.
- R9: In chain mode, `sdo_oe` is 1 in every state.
- R10: After reset the block is idle, in select mode, with `sdo` = 0 and `sdo_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Conversion start strobe; also the select line in three-wire use |
| sdi | input | 1 | Mode select at the strobe edge, read enable, or chain input |
| sck | input | 1 | Host serial clock |
| conv_result | input | DATA_W | Parallel word captured when the conversion ends |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high impedance) |

## Verification
The bench builds every instance with `CONV_CYCLES` = 20 and the default 16-bit word. A short conversion keeps each scenario brief, yet leaves room to drop `cnv` or `sdi` part-way through a conversion and to toggle `sck` during it. Each readback is also long enough to pass the 16- or 17-bit frame, so chain mode is seen delivering the `sdi` bits that follow. A second pair of instances, wired upstream to downstream, shows the 32-bit cascade on a single line.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } sp_state_t;

    typedef enum logic {
        MODE_SEL   = 1'b0,
        MODE_CHAIN = 1'b1
    } sp_mode_t;

endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] din_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] =  din[i] & ~din_q[i];
        assign fall[i] = ~din[i] &  din_q[i];
    end

endmodule

// File: rtl/sp_conv_timer.sv
module sp_conv_timer #(
    parameter int CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign done = running && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= CW'(CYCLES - 1);
        end else if (done) begin
            running <= 1'b0;
        end else if (running) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // R2
    tmr_nonzero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$past(start) && !$past(done)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift_en,
    input  logic              cap_en,
    input  logic              ser_in,
    input  logic              lead_bit,
    output logic              ser_out
);

    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0] sr_q;
    logic            cap_q;

    assign ser_out = lead_bit ? sr_q[SR_W-1] : sr_q[SR_W-2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cap_q <= 1'b0;
        end else begin
            if (cap_en) cap_q <= ser_in;
            if (load)
                sr_q <= {1'b0, load_word};
            else if (shift_en)
                sr_q <= {sr_q[SR_W-2:0], cap_q};
        end
    end

    // R2
    sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(sr_q));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sdi,
    input  logic              sck,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int IDX_CNV = 0;
    localparam int IDX_SDI = 1;
    localparam int IDX_SCK = 2;
    localparam int N_LINES = 3;

    sp_state_t state_q, state_d;
    sp_mode_t  mode_q;
    logic      lead_q;

    logic [N_LINES-1:0] line_now, line_q, line_rise, line_fall;
    logic cnv_rise, sck_rise, sck_fall, sdi_prev, sck_prev;
    logic start, timer_run, timer_done;
    logic selected, shift_en, cap_en, ser_in, shifter_out;

    assign line_now = {sck, sdi, cnv};

    sp_edge_det #(.W(N_LINES)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_now),
        .din_q (line_q),
        .rise  (line_rise),
        .fall  (line_fall)
    );

    assign cnv_rise = line_rise[IDX_CNV];
    assign sck_rise = line_rise[IDX_SCK];
    assign sck_fall = line_fall[IDX_SCK];
    assign sdi_prev = line_q[IDX_SDI];
    assign sck_prev = line_q[IDX_SCK];

    assign start = cnv_rise && (state_q != ST_CONV);

    sp_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .running (timer_run),
        .done    (timer_done)
    );

    sp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (timer_done),
        .load_word (conv_result),
        .shift_en  (shift_en),
        .cap_en    (cap_en),
        .ser_in    (ser_in),
        .lead_bit  (lead_q),
        .ser_out   (shifter_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)      state_d = ST_CONV;
            ST_CONV: if (timer_done) state_d = ST_READ;
            ST_READ: if (start)      state_d = ST_CONV;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_SEL;
            lead_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                mode_q <= sdi_prev ? MODE_SEL : MODE_CHAIN;
                lead_q <= !sdi_prev && sck_prev;
            end else if (timer_done && mode_q == MODE_SEL) begin
                lead_q <= !cnv || !sdi;
            end
        end
    end

    always_comb begin
        selected = (mode_q == MODE_CHAIN) || !cnv || !sdi;
        shift_en = 1'b0;
        cap_en   = 1'b0;
        ser_in   = 1'b0;
        sdo      = 1'b0;
        sdo_oe   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sdo    = shifter_out;
                sdo_oe = (mode_q == MODE_CHAIN);
            end
            ST_CONV: begin
                sdo    = (mode_q == MODE_CHAIN) && lead_q;
                sdo_oe = (mode_q == MODE_CHAIN);
            end
            ST_READ: begin
                shift_en = sck_fall && selected;
                cap_en   = sck_rise && (mode_q == MODE_CHAIN);
                ser_in   = (mode_q == MODE_CHAIN) && sdi;
                sdo      = shifter_out;
                sdo_oe   = selected;
            end
            default: begin
                sdo    = 1'b0;
                sdo_oe = 1'b0;
            end
        endcase
    end

    // R2
    timer_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_done |-> (state_q == ST_CONV));

    // R2
    conv_timer_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> timer_run);

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONV) && $past(state_q == ST_CONV)) |-> $stable(mode_q));

    // R4
    sel_hiz_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONV) && (mode_q == MODE_SEL)) |-> !sdo_oe);

    // R9
    chain_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CHAIN) |-> sdo_oe);

    // R7
    chain_busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONV) && (mode_q == MODE_CHAIN) && lead_q) |-> sdo);

endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;

    localparam int CONV = 20;
    localparam int DW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0;
    logic sck = 1'b0;
    logic sdi_drv = 1'b1;
    logic cas_sdi = 1'b0;
    logic use_cas = 1'b0;
    logic [DW-1:0] res_u = 16'hA5C3;
    logic [DW-1:0] res_a = 16'h1234;
    logic [DW-1:0] res_b = 16'hBEEF;
    logic sdo, sdo_oe, a_sdo, a_oe, b_sdo, b_oe, probe;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi_drv), .sck(sck),
        .conv_result(res_u), .sdo(sdo), .sdo_oe(sdo_oe));

    adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) ua (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(cas_sdi), .sck(sck),
        .conv_result(res_a), .sdo(a_sdo), .sdo_oe(a_oe));

    adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) ub (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(a_sdo), .sck(sck),
        .conv_result(res_b), .sdo(b_sdo), .sdo_oe(b_oe));

    assign probe = use_cas ? b_sdo : sdo;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_bits(input int n, input bit drive, input logic [63:0] feed,
                             output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got = {got[62:0], probe};
            if (drive) sdi_drv = feed[63-i];
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic t_reset;
        chk("R10 sdo after reset", 64'(sdo), 64'd0);
        chk("R10 oe after reset", 64'(sdo_oe), 64'd0);
    endtask

    task automatic t_cascade;
        logic [63:0] got;
        use_cas = 1'b1;
        cas_sdi = 1'b0;
        sdi_drv = 1'b0;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(3);
        cnv = 1'b0;
        wait_clk(CONV + 3);
        chk("R9 upstream drives", 64'(a_oe), 64'd1);
        chk("R9 downstream drives", 64'(b_oe), 64'd1);
        read_bits(34, 1'b0, 64'd0, got);
        chk("R8 cascade stream", got, {30'd0, res_b, res_a, 2'b00});
        use_cas = 1'b0;
    endtask

    task automatic t_sel3_plain;
        logic [63:0] got;
        sdi_drv = 1'b1;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(CONV + 3);
        chk("R4 deselected while cnv high", 64'(sdo_oe), 64'd0);
        cnv = 1'b0;
        wait_clk(2);
        chk("R4 selected on cnv low", 64'(sdo_oe), 64'd1);
        read_bits(16, 1'b0, 64'd0, got);
        chk("R3 three-wire word", got, 64'(res_u));
    endtask

    task automatic t_sel3_busy;
        logic [63:0] got;
        res_u = 16'h8001;
        sdi_drv = 1'b1;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(3);
        cnv = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sck = 1'b1; wait_clk(2); sck = 1'b0; wait_clk(2);
        end
        wait_clk(CONV - 20);
        chk("R2 still converting", 64'(sdo_oe), 64'd0);
        wait_clk(2);
        chk("R2 conversion ended on time", 64'(sdo_oe), 64'd1);
        chk("R6 start bit low", 64'(sdo), 64'd0);
        read_bits(17, 1'b0, 64'd0, got);
        chk("R6 start bit then word", got, {47'd0, 1'b0, res_u});
    endtask

    task automatic t_sel4_plain;
        logic [63:0] got;
        res_u = 16'h3C5A;
        sdi_drv = 1'b1;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(CONV + 3);
        chk("R5 sdi high deselects", 64'(sdo_oe), 64'd0);
        sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(4);
        sdi_drv = 1'b0;
        wait_clk(2);
        chk("R5 sdi low selects", 64'(sdo_oe), 64'd1);
        read_bits(16, 1'b0, 64'd0, got);
        chk("R5 four-wire word unshifted while deselected", got, 64'(res_u));
        sdi_drv = 1'b1;
        cnv = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_sel4_busy;
        logic [63:0] got;
        res_u = 16'hF00D;
        sdi_drv = 1'b1;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(2);
        sdi_drv = 1'b0;
        wait_clk(3);
        cnv = 1'b0;
        wait_clk(2);
        cnv = 1'b1;
        wait_clk(CONV);
        chk("R6 four-wire selected after end", 64'(sdo_oe), 64'd1);
        read_bits(17, 1'b0, 64'd0, got);
        chk("R6 four-wire start bit then word", got, {47'd0, 1'b0, res_u});
        chk("R2 mid-conversion cnv rise ignored", 64'(sdo_oe), 64'd1);
        sdi_drv = 1'b1;
        cnv = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_chain_busy;
        logic [63:0] got;
        res_u = 16'h6E29;
        sdi_drv = 1'b0;
        sck = 1'b1;
        wait_clk(3);
        cnv = 1'b1;
        wait_clk(2);
        sck = 1'b0;
        cnv = 1'b0;
        wait_clk(4);
        chk("R7 sdo high during conversion", 64'(sdo), 64'd1);
        chk("R9 chain drives in conversion", 64'(sdo_oe), 64'd1);
        wait_clk(CONV);
        read_bits(21, 1'b1, {4'b1011, 60'd0}, got);
        chk("R7 start bit, word, chained bits", got, {43'd0, 1'b0, res_u, 4'b1011});
        sdi_drv = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_tied;
        logic [63:0] got;
        res_u = 16'h0F71;
        sdi_drv = 1'b0;
        cnv = 1'b0;
        wait_clk(3);
        cnv = 1'b1;
        sdi_drv = 1'b1;
        wait_clk(3);
        chk("R1 tied lines pick chain", 64'(sdo_oe), 64'd1);
        wait_clk(CONV);
        read_bits(18, 1'b0, 64'd0, got);
        chk("R1 chain word then sdi ones", got, {46'd0, res_u, 2'b11});
        cnv = 1'b0;
        sdi_drv = 1'b1;
        wait_clk(3);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_cascade();
        t_sel3_plain();
        t_sel3_busy();
        t_sel4_plain();
        t_sel4_busy();
        t_chain_busy();
        t_tied();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule